// File: doc/BRIEF.md
# Power-Down Hold Controller

This block sits between a clocked logic core and its pads and freezes the core when either of two power-down pins goes high. While frozen, the core's clock is switched off. The values the core sees on its inputs stay fixed, and the levels and enables on its pads stay fixed too. Pad drivers that were off when the freeze began stay off. Input activity is ignored until both power-down pins are low again.

A configuration bit turns the feature on. With the feature off, the two power-down pins are ordinary logic inputs and never freeze anything. With the feature on, their values are withheld from the core. Each pin input has a drive-valid flag. When the keeper option is built in, a pin that stops being driven keeps reporting the last level that was driven onto it. A power-up reset clears every register in the block to zero.

The power-down pins pass through a synchronizer. The freeze state is then held in a register, so the core clock enable only changes at a clock edge and the core never receives a partial clock pulse.

Top module: `pdh_ctrl`

## Requirements
- R1: With `cfg_pd_en` low, `pd_to_core` equals `{pd_b, pd_a}`, and the power-down pins never freeze the block.
- R2: With `cfg_pd_en` high, a high level on `pd_a` or `pd_b` freezes the block on the third rising clock edge after the level appears. From that edge on, `core_clk_en` is low.
- R3: While frozen, `pad_out` and `pad_oe` keep the values `core_out` and `core_oe` had just before the freezing edge. A pad whose `pad_oe` bit was 0 stays 0.
- R4: While frozen, `core_in` keeps the resolved pin levels present just before the freezing edge, and later pin changes have no effect. While running, `core_in` follows the pins with no added delay.
- R5: With `cfg_pd_en` high, `pd_to_core` reads 0 whatever the power-down pins carry.
- R6: With the keeper option on, a pin whose `pin_drv` bit is 0 reports on `core_in` the level last seen on that pin while its `pin_drv` bit was 1, or 0 if it has never been driven since reset.
- R7: During reset, all internal registers are 0: `core_clk_en` is 1, undriven pins read 0, and the pads follow the core.
- R8: Once both power-down pins are low, the block unfreezes on the third rising edge. From that edge on, `core_clk_en` is 1 and `core_in`, `pad_out` and `pad_oe` are transparent again.
- R9: The freeze persists as long as either power-down pin is high, including when one pin drops while the other is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| cfg_pd_en | input | 1 | Enables the power-down feature |
| pd_a | input | 1 | First power-down pin, active high |
| pd_b | input | 1 | Second power-down pin, active high |
| pin_val | input | N_PINS | Raw pin levels |
| pin_drv | input | N_PINS | Per-pin flag, 1 when the pin is actively driven |
| core_out | input | N_OUT | Output levels from the core |
| core_oe | input | N_OUT | Output enables from the core |
| core_in | output | N_PINS | Resolved, possibly held, pin levels to the core |
| pd_to_core | output | 2 | Power-down pins as data, bit 0 from `pd_a` |
| core_clk_en | output | 1 | Clock enable for the core, low while frozen |
| pad_out | output | N_OUT | Levels to the pads |
| pad_oe | output | N_OUT | Enables to the pads |

## Verification
A wrong freeze state shows up at `core_clk_en` on the edge where the model expects entry or exit. It also shows on the first cycle of the freeze, when the inputs change and `core_in` or the pads would follow them. A capture taken one edge too early or too late makes the frozen values differ from the ones present just before the freezing edge, and this is visible on the first frozen cycle. A keeper that is wrong shows on `core_in` in the same cycle a driver lets go. Random inputs change every cycle, so a stale or leaking path is visible within one clock.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
   typedef enum logic {
      PDH_RUN  = 1'b0,
      PDH_HOLD = 1'b1
   } pdh_state_e;

   localparam int PDH_MIN_SYNC = 2;
endpackage

// File: rtl/pdh_sync.sv
module pdh_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < pdh_pkg::PDH_MIN_SYNC) begin : g_bad_stages
      $error("pdh_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pdh_keeper.sv
module pdh_keeper #(
   parameter int N_PINS    = 8,
   parameter bit KEEPER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_val,
   input  logic [N_PINS-1:0] pin_drv,
   output logic [N_PINS-1:0] level
);
   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      if (KEEPER_EN) begin : g_keep
         logic last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          last_q <= 1'b0;
            else if (pin_drv[i]) last_q <= pin_val[i];
         end
         assign level[i] = pin_drv[i] ? pin_val[i] : last_q;

         // R6
         keeper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pin_drv[i] && $past(pin_drv[i])) |-> (level[i] == $past(pin_val[i])));
      end else begin : g_nokeep
         assign level[i] = pin_drv[i] & pin_val[i];
      end
   end
endmodule

// File: rtl/pdh_hold.sv
module pdh_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] snap_q;

   if (W < 1) begin : g_bad_w
      $error("pdh_hold: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     snap_q <= '0;
      else if (!hold) snap_q <= d;
   end

   assign q = hold ? snap_q : d;

   // R4
   snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $past(hold)) |-> $stable(q));
endmodule

// File: rtl/pdh_ctrl.sv
module pdh_ctrl #(
   parameter int N_PINS      = 8,
   parameter int N_OUT       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit KEEPER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pd_en,
   input  logic              pd_a,
   input  logic              pd_b,
   input  logic [N_PINS-1:0] pin_val,
   input  logic [N_PINS-1:0] pin_drv,
   input  logic [N_OUT-1:0]  core_out,
   input  logic [N_OUT-1:0]  core_oe,
   output logic [N_PINS-1:0] core_in,
   output logic [1:0]        pd_to_core,
   output logic              core_clk_en,
   output logic [N_OUT-1:0]  pad_out,
   output logic [N_OUT-1:0]  pad_oe
);
   import pdh_pkg::*;

   if (N_OUT < 1 || N_PINS < 1) begin : g_bad_width
      $error("pdh_ctrl: pin and output counts must be positive");
   end

   logic              pd_sync;
   logic              pd_req;
   logic              frozen;
   pdh_state_e        state_q;
   logic [N_PINS-1:0] pin_level;

   pdh_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pd_a | pd_b), .q(pd_sync)
   );

   assign pd_req = cfg_pd_en & pd_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= PDH_RUN;
      else if (pd_req) state_q <= PDH_HOLD;
      else             state_q <= PDH_RUN;
   end

   assign frozen      = (state_q == PDH_HOLD);
   assign core_clk_en = ~frozen;
   assign pd_to_core  = cfg_pd_en ? 2'b00 : {pd_b, pd_a};

   pdh_keeper #(.N_PINS(N_PINS), .KEEPER_EN(KEEPER_EN)) u_keeper (
      .clk(clk), .rst_n(rst_n), .pin_val(pin_val), .pin_drv(pin_drv), .level(pin_level)
   );

   pdh_hold #(.W(N_PINS)) u_in_hold (
      .clk(clk), .rst_n(rst_n), .hold(frozen), .d(pin_level), .q(core_in)
   );

   pdh_hold #(.W(N_OUT)) u_out_hold (
      .clk(clk), .rst_n(rst_n), .hold(frozen), .d(core_out), .q(pad_out)
   );

   pdh_hold #(.W(N_OUT)) u_oe_hold (
      .clk(clk), .rst_n(rst_n), .hold(frozen), .d(core_oe), .q(pad_oe)
   );

   // R2
   hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frozen) |-> $past(pd_sync && cfg_pd_en));

   // R1
   disabled_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pd_en |=> !frozen);

   // R3
   pad_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && $past(frozen)) |-> ($stable(pad_out) && $stable(pad_oe)));

   // R8
   clk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_clk_en) |-> $past(!pd_sync || !cfg_pd_en));
endmodule

// File: tb/pdh_ctrl_tb.sv
module pdh_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_pd_en = 1'b1;
   logic       pd_a = 1'b0, pd_b = 1'b0;
   logic [7:0] pin_val = '0, pin_drv = '0, core_out = '0, core_oe = '0;
   logic [7:0] core_in, pad_out, pad_oe;
   logic [1:0] pd_to_core;
   logic       core_clk_en;

   int checks = 0, fails = 0;
   logic [7:0] mk = '0, cin_h = '0, out_h = '0, oe_h = '0;
   logic       s1 = 0, s2 = 0, hq = 0;

   always #2 clk = ~clk;

   pdh_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .pd_a(pd_a), .pd_b(pd_b),
      .pin_val(pin_val), .pin_drv(pin_drv), .core_out(core_out), .core_oe(core_oe),
      .core_in(core_in), .pd_to_core(pd_to_core), .core_clk_en(core_clk_en),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   function automatic logic [7:0] resolve(logic [7:0] v, logic [7:0] d, logic [7:0] k);
      return (d & v) | (~d & k);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step_v(logic pa, logic pb, logic cfg, logic [7:0] v, logic [7:0] d);
      logic [7:0] res;
      @(negedge clk);
      pd_a = pa; pd_b = pb; cfg_pd_en = cfg;
      pin_val = v; pin_drv = d;
      core_out = 8'($urandom); core_oe = 8'($urandom);
      #1;
      res = resolve(v, d, mk);
      chk("R2 clk_en", 32'(core_clk_en), 32'(!hq));
      chk(hq ? "R4 core_in held" : "R6 core_in live", 32'(core_in), 32'(hq ? cin_h : res));
      chk(hq ? "R3 pad_out held" : "R8 pad_out live", 32'(pad_out), 32'(hq ? out_h : core_out));
      chk(hq ? "R3 pad_oe held" : "R8 pad_oe live", 32'(pad_oe), 32'(hq ? oe_h : core_oe));
      chk(cfg ? "R5 pd mask" : "R1 pd data", 32'(pd_to_core), 32'(cfg ? 2'b00 : {pb, pa}));
      @(posedge clk);
      if (!hq) begin cin_h = res; out_h = core_out; oe_h = core_oe; end
      hq = cfg & s2; s2 = s1; s1 = pa | pb;
      mk = res;
   endtask

   task automatic step(logic pa, logic pb, logic cfg);
      step_v(pa, pb, cfg, 8'($urandom), 8'($urandom));
   endtask

   initial begin
      #(4 * 150000);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd7331));
      // R7 reset state
      #3;
      chk("R7 clk_en", 32'(core_clk_en), 32'd1);
      chk("R7 undriven", 32'(core_in), 32'd0);
      core_out = 8'hA5; core_oe = 8'h3C; #1;
      chk("R7 pad follow", 32'(pad_out), 32'hA5);
      @(negedge clk); rst_n = 1'b1;

      // R6 keeper directed
      step_v(0, 0, 1, 8'h81, 8'h81);
      step_v(0, 0, 1, 8'h00, 8'h00);
      chk("R6 kept", 32'(core_in), 32'h81);

      // R2/R3/R4 enter via pd_a, then R9 handover to pd_b
      for (int i = 0; i < 6; i++) step(1, 0, 1);
      chk("R2 frozen", 32'(core_clk_en), 32'd0);
      for (int i = 0; i < 3; i++) step(1, 1, 1);
      for (int i = 0; i < 6; i++) step(0, 1, 1);
      chk("R9 persists", 32'(core_clk_en), 32'd0);
      for (int i = 0; i < 5; i++) step(0, 0, 1);
      chk("R8 released", 32'(core_clk_en), 32'd1);

      // R1 disabled: pins high, no freeze
      for (int i = 0; i < 6; i++) step(1, 1, 0);
      chk("R1 no freeze", 32'(core_clk_en), 32'd1);
      for (int i = 0; i < 4; i++) step(0, 0, 1);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic pa, pb, cfg;
         pa  = ($urandom % 8) == 0 ? ~pd_a : pd_a;
         pb  = ($urandom % 10) == 0 ? ~pd_b : pd_b;
         cfg = ($urandom % 40) == 0 ? ~cfg_pd_en : cfg_pd_en;
         step(pa, pb, cfg);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule